// File: doc/BRIEF.md
# Circular Packet Record Writer

This block takes a stream of fixed-size transport packets, beat by beat, and stores each one as a padded record in a circular buffer in memory. Software sets the lower and upper bounds of the buffer, reads back a write pointer that marks the end of the last complete record, and moves a read pointer forward as it consumes records. A channel enable bit starts and stops the capture of new packets. When the record after the current one would land on the read pointer, the incoming packet is dropped and counted.

Software stops the channel cleanly with an idle request. Once a request is pending, the block starts no new record and lets any record in flight finish. It then raises a level idle interrupt. Software withdraws the request and clears the interrupt by writing zero to the idle register.

Top module: `pkt_ring_writer`

## Requirements
- R1: After reset, every register reads zero, `idle_irq` is low and no memory write occurs. Register indices on `reg_addr`: 0 lower bound, 1 inclusive upper bound, 2 write pointer (read only), 3 read pointer, 4 control (bit 0 = enable), 5 idle request, 6 drop counter.
- R2: An accepted packet is written as one record of 24 beats of 8 bytes (188 + 4 bytes padded up to a multiple of 8, that is 192 bytes). Beat k goes to the byte address write pointer + 8*k.
- R3: Writing 1 to control bit 0 while the channel is disabled loads the write pointer with the lower bound.
- R4: The write pointer moves forward by 192 only in the cycle that the last beat of a record is written. While a record is partly written, it keeps its old value.
- R5: When a record ends so close to the upper bound that the next record would not fit at or below it (pointer + 2*192 - 1 > upper bound), the pointer wraps to the lower bound instead of moving forward.
- R6: When the pointer value after the next record would equal the read pointer, an enabled channel drops the packet on its start beat. It writes nothing, leaves the write pointer unchanged and adds one to the drop counter.
- R7: With control bit 0 clear, a packet start is ignored. No memory write occurs and the drop counter does not change.
- R8: Writing the idle register with bit 31 and bit CHAN_ID (0 by default) both set makes the request pending. With no record in flight, `idle_irq` rises on the next cycle. While the request is pending, no new record starts. Reading the idle register gives bit 31 = request pending and bit 0 = interrupt.
- R9: A non-zero write to the idle register that lacks bit 31 or bit CHAN_ID has no effect.
- R10: A request made in the middle of a record raises `idle_irq` only in the cycle after that record's last beat, and the whole record is still written.
- R11: Writing zero to the idle register clears both the request and `idle_irq`, and new packets are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Marks the first beat of a packet |
| in_data | input | DW | Beat payload |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address of the beat |
| mem_wdata | output | DW | Memory write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| idle_irq | output | 1 | Idle interrupt, level |

## Verification
Packets are sent both as unbroken bursts and with a pause in the middle of a record. The paused case separates a pointer that is published after the whole record from one that follows each beat. A run of packets into an empty ring fills it to capacity, so the drop on the eighth packet and the wrap to the lower bound on the next one are both seen at their exact boundary. Idle requests are made once when the block is quiet and once in the middle of a record. Comparing the interrupt timing in the two cases shows whether the block waits for the record in flight. Malformed idle writes and packets sent while disabled must leave the counters, the pointer and the memory untouched.

// File: rtl/pktr_pkg.sv
package pktr_pkg;
  typedef enum logic [2:0] {
    RA_BASE  = 3'd0,
    RA_TOP   = 3'd1,
    RA_WPTR  = 3'd2,
    RA_RPTR  = 3'd3,
    RA_CTRL  = 3'd4,
    RA_IDLE  = 3'd5,
    RA_DROPS = 3'd6
  } reg_addr_e;

  function automatic int unsigned pad_up(input int unsigned n, input int unsigned a);
    return ((n + a - 1) / a) * a;
  endfunction
endpackage

// File: rtl/pktr_beat.sv
module pktr_beat #(
  parameter int unsigned DW         = 64,
  parameter int unsigned AW         = 32,
  parameter int unsigned REC_BEATS  = 24,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [DW-1:0] in_data,
  input  logic          start_ok,
  input  logic [AW-1:0] wptr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rec_done,
  output logic          sop_reject,
  output logic          busy
);
  localparam int unsigned CW = (REC_BEATS > 1) ? $clog2(REC_BEATS) : 1;

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sop_take, accept, beat_go, last_beat, cnt_en;
  logic [CW-1:0] offset;

  always_comb begin
    sop_take   = in_valid & in_sop & ~active_q;
    accept     = sop_take & start_ok;
    sop_reject = sop_take & ~start_ok;
    beat_go    = in_valid & active_q;
    last_beat  = beat_go & (cnt_q == CW'(REC_BEATS - 1));
    cnt_en     = accept | beat_go;
    active_d   = active_q;
    cnt_d      = cnt_q;
    if (accept) begin
      active_d = 1'b1;
      cnt_d    = CW'(1);
    end else if (beat_go) begin
      active_d = ~last_beat;
      cnt_d    = last_beat ? '0 : cnt_q + CW'(1);
    end
    offset    = accept ? '0 : cnt_q;
    mem_we    = accept | beat_go;
    mem_addr  = wptr + AW'(offset) * AW'(BEAT_BYTES);
    mem_wdata = in_data;
    rec_done  = last_beat;
    busy      = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  // R2
  rec_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: rtl/pktr_wptr.sv
module pktr_wptr #(
  parameter int unsigned AW        = 32,
  parameter int unsigned REC_BYTES = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] top,
  input  logic [AW-1:0] rptr,
  input  logic          load,
  input  logic          advance,
  output logic [AW-1:0] wptr,
  output logic          full
);
  logic [AW-1:0] wptr_q, wptr_d, step, span_end, after;
  logic          wptr_en;

  always_comb begin
    step     = wptr_q + AW'(REC_BYTES);
    span_end = wptr_q + AW'(2 * REC_BYTES - 1);
    after    = (span_end > top) ? base : step;
    full     = (after == rptr);
    wptr_en  = load | advance;
    wptr_d   = load ? base : after;
    wptr     = wptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr_q <= '0;
    else if (wptr_en) wptr_q <= wptr_d;
  end

  // R4
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(wptr_q));
endmodule

// File: rtl/pktr_regs.sv
module pktr_regs
  import pktr_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CHAN_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] wptr,
  input  logic          busy,
  input  logic          drop,
  output logic [AW-1:0] base,
  output logic [AW-1:0] top,
  output logic [AW-1:0] rptr,
  output logic          enable,
  output logic          restart,
  output logic          idle_pend,
  output logic          idle_irq
);
  logic [AW-1:0]    base_q, top_q, rptr_q;
  logic             en_q, en_d;
  logic             pend_q, pend_d, irq_q, irq_d;
  logic [CNT_W-1:0] drops_q;
  logic             wr_base, wr_top, wr_rptr, wr_ctrl, wr_idle;
  logic             idle_valid, idle_clr;

  always_comb begin
    wr_base    = reg_we & (reg_addr == RA_BASE);
    wr_top     = reg_we & (reg_addr == RA_TOP);
    wr_rptr    = reg_we & (reg_addr == RA_RPTR);
    wr_ctrl    = reg_we & (reg_addr == RA_CTRL);
    wr_idle    = reg_we & (reg_addr == RA_IDLE);
    idle_valid = wr_idle & reg_wdata[31] & reg_wdata[CHAN_ID];
    idle_clr   = wr_idle & (reg_wdata == 32'd0);
    en_d       = wr_ctrl ? reg_wdata[0] : en_q;
    restart    = wr_ctrl & reg_wdata[0] & ~en_q;
    pend_d     = idle_clr ? 1'b0 : (idle_valid | pend_q);
    irq_d      = idle_clr ? 1'b0 : (irq_q | (pend_q & ~busy));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      top_q   <= '0;
      rptr_q  <= '0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      drops_q <= '0;
    end else begin
      if (wr_base) base_q <= reg_wdata[AW-1:0];
      if (wr_top)  top_q  <= reg_wdata[AW-1:0];
      if (wr_rptr) rptr_q <= reg_wdata[AW-1:0];
      if (wr_ctrl) en_q   <= en_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
      if (drop) drops_q <= drops_q + CNT_W'(1);
    end
  end

  always_comb begin
    case (reg_addr)
      RA_BASE:  reg_rdata = 32'(base_q);
      RA_TOP:   reg_rdata = 32'(top_q);
      RA_WPTR:  reg_rdata = 32'(wptr);
      RA_RPTR:  reg_rdata = 32'(rptr_q);
      RA_CTRL:  reg_rdata = {31'd0, en_q};
      RA_IDLE:  reg_rdata = {pend_q, 30'd0, irq_q};
      RA_DROPS: reg_rdata = 32'(drops_q);
      default:  reg_rdata = 32'd0;
    endcase
    base      = base_q;
    top       = top_q;
    rptr      = rptr_q;
    enable    = en_q;
    idle_pend = pend_q;
    idle_irq  = irq_q;
  end

  // R10
  irq_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(!busy));

  // R6
  drops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drop |=> $stable(drops_q));
endmodule

// File: rtl/pkt_ring_writer.sv
module pkt_ring_writer #(
  parameter int unsigned DW        = 64,
  parameter int unsigned AW        = 32,
  parameter int unsigned PKT_BYTES = 188,
  parameter int unsigned HDR_BYTES = 4,
  parameter int unsigned PAD_BYTES = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned CHAN_ID   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [DW-1:0] in_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          idle_irq
);
  localparam int unsigned BEAT_BYTES = DW / 8;
  localparam int unsigned REC_BYTES  = pktr_pkg::pad_up(PKT_BYTES + HDR_BYTES, PAD_BYTES);
  localparam int unsigned REC_BEATS  = REC_BYTES / BEAT_BYTES;

  logic [AW-1:0] base, top, rptr, wptr;
  logic          enable, restart, idle_pend, full;
  logic          start_ok, rec_done, sop_reject, busy, drop;

  always_comb begin
    start_ok = enable & ~idle_pend & ~full;
    drop     = sop_reject & enable & ~idle_pend & full;
  end

  pktr_regs #(.AW(AW), .CNT_W(CNT_W), .CHAN_ID(CHAN_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wptr(wptr), .busy(busy),
    .drop(drop), .base(base), .top(top), .rptr(rptr), .enable(enable),
    .restart(restart), .idle_pend(idle_pend), .idle_irq(idle_irq)
  );

  pktr_wptr #(.AW(AW), .REC_BYTES(REC_BYTES)) u_wptr (
    .clk(clk), .rst_n(rst_n), .base(base), .top(top), .rptr(rptr),
    .load(restart), .advance(rec_done), .wptr(wptr), .full(full)
  );

  pktr_beat #(.DW(DW), .AW(AW), .REC_BEATS(REC_BEATS), .BEAT_BYTES(BEAT_BYTES)) u_beat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .start_ok(start_ok), .wptr(wptr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rec_done(rec_done),
    .sop_reject(sop_reject), .busy(busy)
  );

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_irq |-> !mem_we);

  // R4
  done_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> mem_we);
endmodule

// File: tb/pkt_ring_writer_test.sv
`timescale 1ns/1ps
module pkt_ring_writer_test;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] TOP  = 32'h6FF;
  localparam int REC = 192;
  localparam int NB  = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop;
  logic [63:0] in_data;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        idle_irq;

  int n_cmp = 0;
  int n_bad = 0;
  int wcount = 0;
  logic [63:0] memw [0:191];

  always #4 clk = ~clk;

  pkt_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_irq(idle_irq)
  );

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      wcount <= wcount + 1;
      if (mem_addr >= BASE && mem_addr <= TOP)
        memw[(mem_addr - BASE) >> 3] <= mem_wdata;
    end
  end

  function automatic logic [63:0] word(input logic [31:0] seed, input int b);
    return {seed, 32'(b)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic send_beats(input logic [31:0] seed, input int first, input int last);
    for (int b = first; b <= last; b++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (b == 0); in_data = word(seed, b);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic check_rec(input string req, input logic [31:0] seed, input logic [31:0] addr);
    int bad = 0;
    int idx = int'((addr - BASE) >> 3);
    for (int b = 0; b < NB; b++)
      if (memw[idx + b] !== word(seed, b)) bad++;
    chk(req, 32'(bad), 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 reg after reset", v, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, idle_irq}, 32'd0);
    chk("R1 no writes after reset", 32'(wcount), 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    int w0;
    wr(3'd0, BASE); wr(3'd1, TOP); wr(3'd3, BASE); wr(3'd4, 32'd1);
    rd(3'd2, v); chk("R3 wptr loaded on enable", v, BASE);
    w0 = wcount;
    send_beats(32'hA0, 0, NB - 1);
    chk("R2 beats per record", 32'(wcount - w0), 32'(NB));
    check_rec("R2 record contents", 32'hA0, BASE);
    rd(3'd2, v); chk("R4 wptr after record", v, BASE + REC);
  endtask

  task automatic t_partial;
    logic [31:0] v;
    send_beats(32'hB0, 0, 9);
    rd(3'd2, v); chk("R4 wptr held mid record", v, BASE + REC);
    send_beats(32'hB0, 10, NB - 1);
    rd(3'd2, v); chk("R4 wptr after paused record", v, BASE + 2 * REC);
    check_rec("R2 paused record contents", 32'hB0, BASE + REC);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    int w0;
    wr(3'd4, 32'd0);
    w0 = wcount;
    send_beats(32'hC0, 0, NB - 1);
    chk("R7 no writes while disabled", 32'(wcount - w0), 32'd0);
    rd(3'd6, v); chk("R7 drops unchanged while disabled", v, 32'd0);
    wr(3'd4, 32'd1);
    rd(3'd2, v); chk("R3 wptr reloaded on restart", v, BASE);
  endtask

  task automatic t_full;
    logic [31:0] v;
    int w0;
    for (int k = 0; k < 7; k++) send_beats(32'hD0 + 32'(k), 0, NB - 1);
    rd(3'd2, v); chk("R6 wptr after seven records", v, BASE + 7 * REC);
    w0 = wcount;
    send_beats(32'hDF, 0, NB - 1);
    chk("R6 no writes when full", 32'(wcount - w0), 32'd0);
    rd(3'd2, v); chk("R6 wptr unchanged when full", v, BASE + 7 * REC);
    rd(3'd6, v); chk("R6 drop counted", v, 32'd1);
    wr(3'd3, BASE + REC);
    send_beats(32'hE0, 0, NB - 1);
    rd(3'd2, v); chk("R5 wptr wraps to base", v, BASE);
    check_rec("R5 last record below top", 32'hE0, BASE + 7 * REC);
    wr(3'd3, BASE + 3 * REC);
  endtask

  task automatic t_idle_bad;
    logic [31:0] v;
    wr(3'd5, 32'h8000_0000);
    @(negedge clk); @(negedge clk);
    chk("R9 global flag alone ignored", {31'd0, idle_irq}, 32'd0);
    wr(3'd5, 32'h0000_0001);
    @(negedge clk); @(negedge clk);
    rd(3'd5, v); chk("R9 channel bit alone ignored", v, 32'd0);
  endtask

  task automatic t_idle;
    logic [31:0] v;
    int w0;
    wr(3'd5, 32'h8000_0001);
    @(negedge clk);
    chk("R8 irq when quiet", {31'd0, idle_irq}, 32'd1);
    rd(3'd5, v); chk("R8 idle register readback", v, 32'h8000_0001);
    w0 = wcount;
    send_beats(32'hF0, 0, NB - 1);
    chk("R8 no record while pending", 32'(wcount - w0), 32'd0);
    wr(3'd5, 32'd0);
    rd(3'd5, v); chk("R11 request and irq cleared", v, 32'd0);
    send_beats(32'hF1, 0, NB - 1);
    rd(3'd2, v); chk("R11 accepting again", v, BASE + REC);
    check_rec("R11 record after clear", 32'hF1, BASE);
  endtask

  task automatic t_idle_mid;
    logic [31:0] v;
    send_beats(32'h1234, 0, 7);
    wr(3'd5, 32'h8000_0001);
    @(negedge clk);
    chk("R10 irq held during record", {31'd0, idle_irq}, 32'd0);
    send_beats(32'h1234, 8, NB - 1);
    chk("R10 irq not yet at last beat", {31'd0, idle_irq}, 32'd0);
    @(negedge clk);
    chk("R10 irq after record ends", {31'd0, idle_irq}, 32'd1);
    check_rec("R10 record completed", 32'h1234, BASE + REC);
    rd(3'd2, v); chk("R10 wptr after record", v, BASE + 2 * REC);
    wr(3'd5, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_data = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_partial();
    t_disable();
    t_full();
    t_idle_bad();
    t_idle();
    t_idle_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule